// File: doc/BRIEF.md
# Tag-Tracking Vector Register File

This block is a vector register file in which each wide register holds a validity bit for every 128-bit slot. Software can therefore park packed capabilities in a vector register, for example during a bulk copy, without losing their validity. Each register is 512 bits wide, split into four slots, and there are sixteen registers. A write names a register, a width (one, two or four slots, or the full register), the data, one incoming tag per slot, and an operation class. The class decides which tags are stored.

A move or tag-preserving transfer copies the incoming tags into the slots it writes. Any other change to a register clears the tags of every slot it writes, so a value that was altered can never keep a set tag. There is one exception, a half-preserving shuffle class: it keeps the tags of the lower half of the written slots, which the shuffle leaves untouched, and clears the tags of the upper half. A write narrower than the register stores zero data and clear tags in the slots above its width.

The read port is combinational. A write is seen on the read port from the clock edge that samples it. An ordinary load or arithmetic result is written with the clear-all class, so its slots land with tags at zero. Ordinary stores should ignore the read tags.

Top module: `tvrf_top`

## Requirements
- R1: A synchronous reset sets the data and tags of every register to zero.
- R2: A write becomes visible on the read port only after the rising edge that samples wr_en high. Before that edge the read port shows the old contents. With wr_en low an edge changes nothing.
- R3: Class code 01 (move or tag-preserving transfer) stores wr_tags[s] as the tag of each written slot s.
- R4: The width code selects the written slots, counted from slot 0 (bits 127:0): 00 selects 1 slot, 01 selects 2, 10 selects 4, and 11 selects every slot of the register. Unselected slots receive zero data and a zero tag.
- R5: Class code 00 (clear-all) stores a zero tag in every written slot.
- R6: Class code 10 (half-preserving shuffle) with width 01 or 10 stores wr_tags[s] for the lower half of the written slots and a zero tag for the upper half.
- R7: Class code 10 with width 00 (a single slot) stores a zero tag.
- R8: Class code 11 is reserved and behaves exactly like class 00.
- R9: A write changes only the register named by wr_idx.
- R10: The data of every written slot is stored unchanged whatever the class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Register written |
| wr_width | input | 2 | Write width code (see R4) |
| wr_class | input | 2 | Operation class code (see R3, R5 to R8) |
| wr_data | input | 512 | Write data, slot 0 in bits 127:0 |
| wr_tags | input | 4 | Incoming tag per slot, bit s for slot s |
| rd_idx | input | 4 | Register read |
| rd_data | output | 512 | Data of register rd_idx |
| rd_tags | output | 4 | Tags of register rd_idx |

## Verification
A wrong tag decision shows up on rd_tags at the first read of the written register after the edge that stored it. The bench therefore reads back every write immediately, over all width codes, class codes and tag patterns. Leaking data or tags between registers only shows up when an untouched register is read later, so the bench sweeps the whole file against a model after the write sweep. Because reads are combinational, a write that lands too early can be seen before the storing edge. The bench also checks the read port in that window.

// File: rtl/tvrf_pkg.sv
package tvrf_pkg;
   typedef enum logic [1:0] {
      OPC_CLEAR = 2'b00,
      OPC_MOVE  = 2'b01,
      OPC_HALF  = 2'b10,
      OPC_RSVD  = 2'b11
   } op_class_e;

   typedef enum logic [1:0] {
      WID_ONE  = 2'b00,
      WID_TWO  = 2'b01,
      WID_FOUR = 2'b10,
      WID_ALL  = 2'b11
   } op_width_e;
endpackage

// File: rtl/tvrf_slot_span.sv
// Turns a width code into per-slot masks: slots written, and the lower
// half of the written slots (used by the half-preserving class).
module tvrf_slot_span
   import tvrf_pkg::*;
#(
   parameter int NSLOT = 4
) (
   input  op_width_e        width,
   output logic [NSLOT-1:0] active,
   output logic [NSLOT-1:0] lower
);
   int unsigned span;

   always_comb begin
      case (width)
         WID_ONE:  span = 1;
         WID_TWO:  span = 2;
         WID_FOUR: span = 4;
         WID_ALL:  span = NSLOT;
      endcase
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign active[s] = (s < span);
      assign lower[s]  = (s < span / 2);
   end
endmodule

// File: rtl/tvrf_tag_policy.sv
// Per-slot tag decision from the operation class.
module tvrf_tag_policy
   import tvrf_pkg::*;
#(
   parameter int NSLOT = 4
) (
   input  op_class_e        cls,
   input  logic [NSLOT-1:0] active,
   input  logic [NSLOT-1:0] lower,
   input  logic [NSLOT-1:0] tags_in,
   output logic [NSLOT-1:0] tags_out
);
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      always_comb begin
         case (cls)
            OPC_MOVE: tags_out[s] = tags_in[s] & active[s];
            OPC_HALF: tags_out[s] = tags_in[s] & lower[s];
            default:  tags_out[s] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/tvrf_data_shaper.sv
// Passes written slots through and zeroes the slots above the width.
module tvrf_data_shaper #(
   parameter int REG_W  = 512,
   parameter int SLOT_W = 128,
   parameter int NSLOT  = REG_W / SLOT_W
) (
   input  logic [NSLOT-1:0] active,
   input  logic [REG_W-1:0] data_in,
   output logic [REG_W-1:0] data_out
);
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign data_out[s*SLOT_W +: SLOT_W] =
         active[s] ? data_in[s*SLOT_W +: SLOT_W] : '0;
   end
endmodule

// File: rtl/tvrf_storage.sv
module tvrf_storage #(
   parameter int NUM_REGS = 16,
   parameter int REG_W    = 512,
   parameter int NSLOT    = 4,
   parameter int IDX_W    = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [REG_W-1:0] wdata,
   input  logic [NSLOT-1:0] wtags,
   input  logic [IDX_W-1:0] ridx,
   output logic [REG_W-1:0] rdata,
   output logic [NSLOT-1:0] rtags
);
   logic [REG_W-1:0] data_q [NUM_REGS];
   logic [NSLOT-1:0] tag_q  [NUM_REGS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int r = 0; r < NUM_REGS; r++) begin
            data_q[r] <= '0;
            tag_q[r]  <= '0;
         end
      end else if (we) begin
         data_q[widx] <= wdata;
         tag_q[widx]  <= wtags;
      end
   end

   assign rdata = data_q[ridx];
   assign rtags = tag_q[ridx];
endmodule

// File: rtl/tvrf_top.sv
module tvrf_top
   import tvrf_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int REG_W    = 512,
   parameter int SLOT_W   = 128,
   parameter int NSLOT    = REG_W / SLOT_W,
   parameter int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [1:0]       wr_width,
   input  logic [1:0]       wr_class,
   input  logic [REG_W-1:0] wr_data,
   input  logic [NSLOT-1:0] wr_tags,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [REG_W-1:0] rd_data,
   output logic [NSLOT-1:0] rd_tags
);
   if (REG_W % SLOT_W != 0) begin : g_bad_slot
      $error("REG_W must be a whole number of slots");
   end
   if (NSLOT != REG_W / SLOT_W) begin : g_bad_nslot
      $error("NSLOT must equal REG_W / SLOT_W");
   end
   if (NSLOT < 4 || (NSLOT & (NSLOT - 1)) != 0) begin : g_bad_pow
      $error("NSLOT must be a power of two of at least 4");
   end
   if ((1 << IDX_W) != NUM_REGS) begin : g_bad_idx
      $error("NUM_REGS must equal 2**IDX_W");
   end

   logic [NSLOT-1:0] active, lower, tags_w;
   logic [REG_W-1:0] data_w;

   tvrf_slot_span #(.NSLOT(NSLOT)) u_span (
      .width  (op_width_e'(wr_width)),
      .active (active),
      .lower  (lower)
   );

   tvrf_tag_policy #(.NSLOT(NSLOT)) u_policy (
      .cls      (op_class_e'(wr_class)),
      .active   (active),
      .lower    (lower),
      .tags_in  (wr_tags),
      .tags_out (tags_w)
   );

   tvrf_data_shaper #(.REG_W(REG_W), .SLOT_W(SLOT_W), .NSLOT(NSLOT)) u_shape (
      .active   (active),
      .data_in  (wr_data),
      .data_out (data_w)
   );

   tvrf_storage #(
      .NUM_REGS (NUM_REGS),
      .REG_W    (REG_W),
      .NSLOT    (NSLOT),
      .IDX_W    (IDX_W)
   ) u_store (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en),
      .widx  (wr_idx),
      .wdata (data_w),
      .wtags (tags_w),
      .ridx  (rd_idx),
      .rdata (rd_data),
      .rtags (rd_tags)
   );
endmodule

// File: rtl/tvrf_checker.sv
module tvrf_checker #(
   parameter int REG_W  = 512,
   parameter int SLOT_W = 128,
   parameter int NSLOT  = 4,
   parameter int IDX_W  = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_idx,
   input logic [1:0]       wr_width,
   input logic [1:0]       wr_class,
   input logic [REG_W-1:0] wr_data,
   input logic [NSLOT-1:0] wr_tags,
   input logic [IDX_W-1:0] rd_idx,
   input logic [REG_W-1:0] rd_data,
   input logic [NSLOT-1:0] rd_tags
);
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (rd_data == '0 && rd_tags == '0));

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> (rd_idx != $past(rd_idx)) || ($stable(rd_data) && $stable(rd_tags)));

   p_move_tags_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_class == 2'b01 && wr_width == 2'b10)
      |=> (rd_idx != $past(wr_idx)) || (rd_tags[3:0] == $past(wr_tags[3:0])));

   p_narrow_zero_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_width == 2'b00)
      |=> (rd_idx != $past(wr_idx))
          || (rd_data[REG_W-1:SLOT_W] == '0 && rd_tags[NSLOT-1:1] == '0));

   p_clear_tags_r5: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_class == 2'b00)
      |=> (rd_idx != $past(wr_idx)) || (rd_tags == '0));

   p_half_tags_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_class == 2'b10 && wr_width == 2'b10)
      |=> (rd_idx != $past(wr_idx))
          || (rd_tags[NSLOT-1:2] == '0 && rd_tags[1:0] == $past(wr_tags[1:0])));

   p_half_single_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_class == 2'b10 && wr_width == 2'b00)
      |=> (rd_idx != $past(wr_idx)) || (rd_tags == '0));

   p_reserved_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_class == 2'b11)
      |=> (rd_idx != $past(wr_idx)) || (rd_tags == '0));

   p_full_data_r10: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_width == 2'b10)
      |=> (rd_idx != $past(wr_idx))
          || (rd_data[4*SLOT_W-1:0] == $past(wr_data[4*SLOT_W-1:0])));
endmodule

bind tvrf_top tvrf_checker #(
   .REG_W  (REG_W),
   .SLOT_W (SLOT_W),
   .NSLOT  (NSLOT),
   .IDX_W  (IDX_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wr_en    (wr_en),
   .wr_idx   (wr_idx),
   .wr_width (wr_width),
   .wr_class (wr_class),
   .wr_data  (wr_data),
   .wr_tags  (wr_tags),
   .rd_idx   (rd_idx),
   .rd_data  (rd_data),
   .rd_tags  (rd_tags)
);

// File: tb/tb_tvrf_top.sv
module tb_tvrf_top;
   localparam int NR = 16;
   localparam int RW = 512;
   localparam int SW = 128;
   localparam int NS = 4;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst;
   logic          wr_en;
   logic [IW-1:0] wr_idx;
   logic [1:0]    wr_width;
   logic [1:0]    wr_class;
   logic [RW-1:0] wr_data;
   logic [NS-1:0] wr_tags;
   logic [IW-1:0] rd_idx;
   logic [RW-1:0] rd_data;
   logic [NS-1:0] rd_tags;

   always #5 clk = ~clk;

   tvrf_top dut (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_width (wr_width),
      .wr_class (wr_class),
      .wr_data  (wr_data),
      .wr_tags  (wr_tags),
      .rd_idx   (rd_idx),
      .rd_data  (rd_data),
      .rd_tags  (rd_tags)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [RW-1:0] m_data [NR];
   logic [NS-1:0] m_tag  [NR];

   task automatic chk_data(string req, logic [RW-1:0] act, logic [RW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s data act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic chk_tags(string req, logic [NS-1:0] act, logic [NS-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s tags act=%b exp=%b", req, act, exp);
      end
   endtask

   function automatic int span_of(logic [1:0] w);
      int n;
      n = (w == 2'd3) ? NS : (1 << w);
      if (n > NS) n = NS;
      return n;
   endfunction

   function automatic logic [NS-1:0] exp_tags(logic [1:0] w, logic [1:0] cls,
                                              logic [NS-1:0] t);
      logic [NS-1:0] r;
      int n;
      n = span_of(w);
      r = '0;
      for (int s = 0; s < NS; s++) begin
         if (s < n) begin
            if (cls == 2'b01) r[s] = t[s];
            else if (cls == 2'b10) r[s] = (s < n / 2) ? t[s] : 1'b0;
         end
      end
      return r;
   endfunction

   function automatic logic [RW-1:0] exp_data(logic [1:0] w, logic [RW-1:0] d);
      logic [RW-1:0] r;
      int n;
      n = span_of(w);
      r = d;
      for (int s = 0; s < NS; s++)
         if (s >= n) r[s*SW +: SW] = '0;
      return r;
   endfunction

   function automatic logic [RW-1:0] pattern(int idx, int cls, int w, int t);
      logic [RW-1:0] r;
      for (int k = 0; k < RW / 32; k++)
         r[k*32 +: 32] = {idx[3:0], cls[3:0], w[3:0], t[3:0], 16'(k * 7 + 1)};
      return r;
   endfunction

   function automatic string tag_req(logic [1:0] w, logic [1:0] cls);
      case (cls)
         2'b00:   return "R5";
         2'b01:   return "R3";
         2'b10:   return (w == 2'b00) ? "R7" : "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic do_write(int idx, logic [1:0] w, logic [1:0] cls,
                           logic [RW-1:0] d, logic [NS-1:0] t);
      @(negedge clk);
      wr_en    = 1'b1;
      wr_idx   = IW'(idx);
      wr_width = w;
      wr_class = cls;
      wr_data  = d;
      wr_tags  = t;
      rd_idx   = IW'(idx);
      #1;
      chk_data("R2", rd_data, m_data[idx]);   // old value before the edge
      chk_tags("R2", rd_tags, m_tag[idx]);
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      m_data[idx] = exp_data(w, d);
      m_tag[idx]  = exp_tags(w, cls, t);
      #1;
      chk_data((w == 2'b10) ? "R10" : "R4", rd_data, m_data[idx]);
      chk_tags(tag_req(w, cls), rd_tags, m_tag[idx]);
   endtask

   task automatic sweep_all(string req);
      for (int r = 0; r < NR; r++) begin
         @(negedge clk);
         rd_idx = IW'(r);
         #1;
         chk_data(req, rd_data, m_data[r]);
         chk_tags(req, rd_tags, m_tag[r]);
      end
   endtask

   task automatic print_summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R2 watchdog act=running exp=finished");
         print_summary();
         $finish;
      end
   end

   initial begin
      rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_width = '0; wr_class = '0;
      wr_data = '0; wr_tags = '0; rd_idx = '0;
      for (int r = 0; r < NR; r++) begin
         m_data[r] = '0;
         m_tag[r]  = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      sweep_all("R1");

      // full sweep: every class, width code and tag pattern
      for (int cls = 0; cls < 4; cls++)
         for (int w = 0; w < 4; w++)
            for (int t = 0; t < 16; t++)
               do_write((cls * 4 + w + t * 3) % NR, 2'(w), 2'(cls),
                        pattern(t, cls, w, t), 4'(t));

      // R9: no other register disturbed
      sweep_all("R9");

      // R2: idle edges change nothing
      @(negedge clk);
      wr_en = 1'b0; wr_idx = 4'd5; wr_width = 2'b10; wr_class = 2'b01;
      wr_data = {RW{1'b1}}; wr_tags = '1;
      repeat (2) @(posedge clk);
      sweep_all("R2");

      // R1: reset after traffic clears everything
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      rst = 1'b0;
      for (int r = 0; r < NR; r++) begin
         m_data[r] = '0;
         m_tag[r]  = '0;
      end
      sweep_all("R1");

      done = 1'b1;
      print_summary();
      $finish;
   end
endmodule